// File: doc/BRIEF.md
# Split Instruction/Data Request Dispatcher

This block sits between a processor's request queue, the inbound coherence message port from the private next-level cache, and the coherence controller of a split first-level cache. Each cycle it looks at the head of both inputs. It drives one lookup address to the instruction and data tag arrays and reads back, for each array, whether the line hits, whether its set still has a free way, and which line would be evicted. From these it picks at most one event for the controller. The event carries a kind, a target address and a cache select.

Inbound messages always win over processor requests. Their class is translated to an event kind, and an upgrade request is treated as a forwarded exclusive request. A processor request is first sorted by type. Instruction fetches go to the instruction cache and everything else goes to the data cache. If the chosen cache misses but the other cache holds the line, the dispatcher first asks for that copy to be evicted. If the chosen set is full, it asks for the victim supplied by the array to be evicted. A processor request leaves its queue only when its demand event goes out. After an eviction event it stays at the head and is evaluated again on the next cycle.

Top module: `req_dispatch`

## Requirements
- R1: Processor request types are coded on 3 bits: 0 load, 1 instruction fetch, 2 store, 3 atomic. Event kinds are coded on 4 bits: 0 load, 1 fetch, 2 store, 3 evict. Load gives event 0, fetch gives event 1, and both store and atomic give event 2.
- R2: A fetch is looked up in the instruction cache (select 1) and every other type in the data cache (select 0). A hit in that cache issues the demand event for the request address with that select, and pops the request in the same cycle.
- R3: If the chosen cache misses and the other cache hits, an evict event (3) is issued for the request address with the other cache's select. The request is not popped. A line is never present in both caches at once.
- R4: If the chosen cache misses, the line is in neither cache, and the chosen set has a free way, the demand event is issued with the chosen select and the request is popped.
- R5: If the chosen cache misses, the line is in neither cache, and the chosen set is full, an evict event is issued for that cache's victim address with the chosen select. The request is not popped.
- R6: Inbound classes are coded on 4 bits and map to event kinds:
  - 0 exclusive data maps to 8; 1 data maps to 7; 2 stale data maps to 9.
  - 3 ack maps to 10; 4 writeback ack maps to 11; 5 invalidate maps to 12.
  - 6 exclusive request and 7 upgrade both map to 4.
  - 8 shared request maps to 5; 9 instruction request maps to 6.
  - The event uses the message address, its select is the instruction-cache hit, and the message is popped.
- R7: When both inputs are valid, only the inbound message is served. The lookup address is the message address whenever a message is valid, and the request address otherwise.
- R8: An undefined processor type (4 to 7) or inbound class (10 to 15) issues no event. The entry is popped and `cpu_err` or `net_err` pulses for one cycle. At most one entry is popped per cycle.
- R9: While `ctl_ready` is low nothing is popped, and the next cycle shows no event and no error.
- R10: Event outputs are registered, appearing one cycle after the decision. During and right after reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_ready | input | 1 | Controller can take an event this cycle |
| cpu_valid | input | 1 | Processor request at head of queue |
| cpu_kind | input | 3 | Request type code |
| cpu_addr | input | AW | Request line address |
| cpu_pop | output | 1 | Consume the processor request |
| net_valid | input | 1 | Inbound message at head of port |
| net_class | input | 4 | Inbound message class code |
| net_addr | input | AW | Inbound message line address |
| net_pop | output | 1 | Consume the inbound message |
| lookup_addr | output | AW | Address presented to both tag arrays |
| ic_hit | input | 1 | Instruction cache holds lookup line |
| dc_hit | input | 1 | Data cache holds lookup line |
| ic_free | input | 1 | Instruction cache set has a free way |
| dc_free | input | 1 | Data cache set has a free way |
| ic_victim | input | AW | Instruction cache victim line address |
| dc_victim | input | AW | Data cache victim line address |
| evt_valid | output | 1 | Event issued (registered) |
| evt_kind | output | 4 | Event kind code |
| evt_addr | output | AW | Event target address |
| evt_sel | output | 1 | Target cache: 1 instruction, 0 data |
| cpu_err | output | 1 | Undefined request type seen |
| net_err | output | 1 | Undefined inbound class seen |

## Verification
The bench targets the cases where a miss needs an eviction first: a line present only in the opposite cache, and a full set with no copy anywhere. A design that popped the request on these cases would lose the access. A design that chose the wrong cache would evict the wrong line or the victim of the wrong array. It also drives a message and a request together, and a bad class next to a valid request. A broken priority or pop rule would then serve both, or serve the request in the same cycle. Finally it maps every inbound class. This catches an upgrade that is not folded into the exclusive-request event, and a cache select that ignores the instruction-cache hit.

// File: rtl/req_dispatch_pkg.sv
package req_dispatch_pkg;

    typedef enum logic [3:0] {
        EV_LOAD       = 4'd0,
        EV_FETCH      = 4'd1,
        EV_STORE      = 4'd2,
        EV_EVICT      = 4'd3,
        EV_FWD_EXCL   = 4'd4,
        EV_FWD_SHARED = 4'd5,
        EV_FWD_INSTR  = 4'd6,
        EV_DATA       = 4'd7,
        EV_DATA_EXCL  = 4'd8,
        EV_DATA_STALE = 4'd9,
        EV_ACK        = 4'd10,
        EV_WB_ACK     = 4'd11,
        EV_INVAL      = 4'd12
    } evt_e;

    localparam int KIND_W  = 3;
    localparam int CLASS_W = 4;

endpackage

// File: rtl/req_cpu_decode.sv
module req_cpu_decode
    import req_dispatch_pkg::*;
(
    input  logic [KIND_W-1:0] kind,
    output evt_e              demand,
    output logic              want_icache,
    output logic              bad
);
    always_comb begin
        demand      = EV_LOAD;
        want_icache = 1'b0;
        bad         = 1'b0;
        unique case (kind)
            3'd0: demand = EV_LOAD;
            3'd1: begin
                demand      = EV_FETCH;
                want_icache = 1'b1;
            end
            3'd2, 3'd3: demand = EV_STORE;
            default: bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/req_net_decode.sv
module req_net_decode
    import req_dispatch_pkg::*;
(
    input  logic [CLASS_W-1:0] cls,
    output evt_e               kind,
    output logic               bad
);
    always_comb begin
        kind = EV_DATA;
        bad  = 1'b0;
        unique case (cls)
            4'd0:       kind = EV_DATA_EXCL;
            4'd1:       kind = EV_DATA;
            4'd2:       kind = EV_DATA_STALE;
            4'd3:       kind = EV_ACK;
            4'd4:       kind = EV_WB_ACK;
            4'd5:       kind = EV_INVAL;
            4'd6, 4'd7: kind = EV_FWD_EXCL;
            4'd8:       kind = EV_FWD_SHARED;
            4'd9:       kind = EV_FWD_INSTR;
            default:    bad  = 1'b1;
        endcase
    end
endmodule

// File: rtl/req_arbiter.sv
module req_arbiter
    import req_dispatch_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_ready,
    input  logic          cpu_valid,
    input  logic [AW-1:0] cpu_addr,
    input  evt_e          cpu_demand,
    input  logic          cpu_want_i,
    input  logic          cpu_bad,
    input  logic          net_valid,
    input  logic [AW-1:0] net_addr,
    input  evt_e          net_kind,
    input  logic          net_bad,
    input  logic          ic_hit,
    input  logic          dc_hit,
    input  logic          ic_free,
    input  logic          dc_free,
    input  logic [AW-1:0] ic_victim,
    input  logic [AW-1:0] dc_victim,
    output logic          issue,
    output evt_e          kind,
    output logic [AW-1:0] addr,
    output logic          sel,
    output logic          cpu_pop,
    output logic          net_pop,
    output logic          cpu_err,
    output logic          net_err
);
    logic          want_hit;
    logic          other_hit;
    logic          want_free;
    logic [AW-1:0] want_victim;

    assign want_hit    = cpu_want_i ? ic_hit    : dc_hit;
    assign other_hit   = cpu_want_i ? dc_hit    : ic_hit;
    assign want_free   = cpu_want_i ? ic_free   : dc_free;
    assign want_victim = cpu_want_i ? ic_victim : dc_victim;

    always_comb begin
        issue   = 1'b0;
        kind    = EV_LOAD;
        addr    = cpu_addr;
        sel     = 1'b0;
        cpu_pop = 1'b0;
        net_pop = 1'b0;
        cpu_err = 1'b0;
        net_err = 1'b0;
        if (ctl_ready) begin
            if (net_valid) begin
                net_pop = 1'b1;
                if (net_bad) begin
                    net_err = 1'b1;
                end else begin
                    issue = 1'b1;
                    kind  = net_kind;
                    addr  = net_addr;
                    sel   = ic_hit;
                end
            end else if (cpu_valid) begin
                if (cpu_bad) begin
                    cpu_pop = 1'b1;
                    cpu_err = 1'b1;
                end else if (want_hit) begin
                    issue   = 1'b1;
                    kind    = cpu_demand;
                    sel     = cpu_want_i;
                    cpu_pop = 1'b1;
                end else if (other_hit) begin
                    issue = 1'b1;
                    kind  = EV_EVICT;
                    sel   = ~cpu_want_i;
                end else if (want_free) begin
                    issue   = 1'b1;
                    kind    = cpu_demand;
                    sel     = cpu_want_i;
                    cpu_pop = 1'b1;
                end else begin
                    issue = 1'b1;
                    kind  = EV_EVICT;
                    addr  = want_victim;
                    sel   = cpu_want_i;
                end
            end
        end
    end

    // R8
    one_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cpu_pop, net_pop}));

    // R7
    net_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_ready && net_valid) |-> !cpu_pop);

endmodule

// File: rtl/req_dispatch.sv
module req_dispatch
    import req_dispatch_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_ready,
    input  logic               cpu_valid,
    input  logic [KIND_W-1:0]  cpu_kind,
    input  logic [AW-1:0]      cpu_addr,
    output logic               cpu_pop,
    input  logic               net_valid,
    input  logic [CLASS_W-1:0] net_class,
    input  logic [AW-1:0]      net_addr,
    output logic               net_pop,
    output logic [AW-1:0]      lookup_addr,
    input  logic               ic_hit,
    input  logic               dc_hit,
    input  logic               ic_free,
    input  logic               dc_free,
    input  logic [AW-1:0]      ic_victim,
    input  logic [AW-1:0]      dc_victim,
    output logic               evt_valid,
    output logic [3:0]         evt_kind,
    output logic [AW-1:0]      evt_addr,
    output logic               evt_sel,
    output logic               cpu_err,
    output logic               net_err
);
    typedef struct packed {
        logic          vld;
        evt_e          kind;
        logic [AW-1:0] addr;
        logic          sel;
        logic          cerr;
        logic          nerr;
    } out_t;

    out_t out_d, out_q;

    evt_e          cpu_demand_w, net_kind_w, arb_kind_w;
    logic          cpu_want_i_w, cpu_bad_w, net_bad_w;
    logic          arb_issue_w, arb_sel_w, arb_cerr_w, arb_nerr_w;
    logic [AW-1:0] arb_addr_w;

    assign lookup_addr = net_valid ? net_addr : cpu_addr;

    req_cpu_decode u_cpu_dec (
        .kind        (cpu_kind),
        .demand      (cpu_demand_w),
        .want_icache (cpu_want_i_w),
        .bad         (cpu_bad_w)
    );

    req_net_decode u_net_dec (
        .cls  (net_class),
        .kind (net_kind_w),
        .bad  (net_bad_w)
    );

    req_arbiter #(.AW(AW)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_ready  (ctl_ready),
        .cpu_valid  (cpu_valid),
        .cpu_addr   (cpu_addr),
        .cpu_demand (cpu_demand_w),
        .cpu_want_i (cpu_want_i_w),
        .cpu_bad    (cpu_bad_w),
        .net_valid  (net_valid),
        .net_addr   (net_addr),
        .net_kind   (net_kind_w),
        .net_bad    (net_bad_w),
        .ic_hit     (ic_hit),
        .dc_hit     (dc_hit),
        .ic_free    (ic_free),
        .dc_free    (dc_free),
        .ic_victim  (ic_victim),
        .dc_victim  (dc_victim),
        .issue      (arb_issue_w),
        .kind       (arb_kind_w),
        .addr       (arb_addr_w),
        .sel        (arb_sel_w),
        .cpu_pop    (cpu_pop),
        .net_pop    (net_pop),
        .cpu_err    (arb_cerr_w),
        .net_err    (arb_nerr_w)
    );

    always_comb begin
        out_d      = out_q;
        out_d.vld  = arb_issue_w;
        out_d.cerr = arb_cerr_w;
        out_d.nerr = arb_nerr_w;
        if (arb_issue_w) begin
            out_d.kind = arb_kind_w;
            out_d.addr = arb_addr_w;
            out_d.sel  = arb_sel_w;
        end else begin
            out_d.kind = EV_LOAD;
            out_d.addr = '0;
            out_d.sel  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign evt_valid = out_q.vld;
    assign evt_kind  = out_q.kind;
    assign evt_addr  = out_q.addr;
    assign evt_sel   = out_q.sel;
    assign cpu_err   = out_q.cerr;
    assign net_err   = out_q.nerr;

    // R3
    excl_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid || net_valid) |-> !(ic_hit && dc_hit));

    // R4
    pop_means_demand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_pop |=> ((evt_valid && evt_kind != 4'd3) || cpu_err));

    // R9
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_ready |=> (!evt_valid && !cpu_err && !net_err));

    // R8
    err_no_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_err || net_err) |-> !evt_valid);

endmodule

// File: tb/tb_req_dispatch.sv
`timescale 1ns/1ps
module tb_req_dispatch;
    localparam int AW = 32;
    localparam logic [AW-1:0] A_CPU = 32'h100, A_NET = 32'h200, A_IV = 32'h300, A_DV = 32'h400;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ctl_ready = 1'b0, cpu_valid = 1'b0, net_valid = 1'b0;
    logic [2:0] cpu_kind = '0;
    logic [3:0] net_class = '0;
    logic ic_hit = 1'b0, dc_hit = 1'b0, ic_free = 1'b0, dc_free = 1'b0;
    logic cpu_pop, net_pop, evt_valid, evt_sel, cpu_err, net_err;
    logic [3:0] evt_kind;
    logic [AW-1:0] lookup_addr, evt_addr;

    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    req_dispatch #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .ctl_ready(ctl_ready),
        .cpu_valid(cpu_valid), .cpu_kind(cpu_kind), .cpu_addr(A_CPU), .cpu_pop(cpu_pop),
        .net_valid(net_valid), .net_class(net_class), .net_addr(A_NET), .net_pop(net_pop),
        .lookup_addr(lookup_addr), .ic_hit(ic_hit), .dc_hit(dc_hit),
        .ic_free(ic_free), .dc_free(dc_free), .ic_victim(A_IV), .dc_victim(A_DV),
        .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_addr(evt_addr), .evt_sel(evt_sel),
        .cpu_err(cpu_err), .net_err(net_err)
    );

    task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    typedef struct packed {
        int       req;
        bit       cv; bit [2:0] ck; bit nv; bit [3:0] nc;
        bit       ih; bit dh; bit fi; bit fd; bit rdy;
        bit       ev; bit [3:0] ek; bit es; bit [1:0] asel;
        bit       cp; bit np; bit ce; bit ne;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{2, 1,0,0,0,  0,1,0,0,1, 1,0,0,0,   1,0,0,0}, // R2 load hit
        '{2, 1,1,0,0,  1,0,0,0,1, 1,1,1,0,   1,0,0,0}, // R2 fetch hit
        '{1, 1,2,0,0,  0,1,0,0,1, 1,2,0,0,   1,0,0,0}, // R1 store
        '{1, 1,3,0,0,  0,1,0,0,1, 1,2,0,0,   1,0,0,0}, // R1 atomic
        '{3, 1,0,0,0,  1,0,1,1,1, 1,3,1,0,   0,0,0,0}, // R3 load in icache
        '{3, 1,1,0,0,  0,1,1,1,1, 1,3,0,0,   0,0,0,0}, // R3 fetch in dcache
        '{4, 1,0,0,0,  0,0,0,1,1, 1,0,0,0,   1,0,0,0}, // R4 load miss free
        '{4, 1,1,0,0,  0,0,1,0,1, 1,1,1,0,   1,0,0,0}, // R4 fetch miss free
        '{5, 1,2,0,0,  0,0,1,0,1, 1,3,0,3,   0,0,0,0}, // R5 store set full
        '{5, 1,1,0,0,  0,0,0,1,1, 1,3,1,2,   0,0,0,0}, // R5 fetch set full
        '{8, 1,5,0,0,  0,1,0,0,1, 0,0,0,0,   1,0,1,0}, // R8 bad type
        '{8, 1,7,0,0,  0,0,0,0,1, 0,0,0,0,   1,0,1,0}, // R8 bad type
        '{6, 0,0,1,7,  0,0,0,0,1, 1,4,0,1,   0,1,0,0}, // R6 upgrade
        '{6, 0,0,1,6,  1,0,0,0,1, 1,4,1,1,   0,1,0,0}, // R6 excl req icache
        '{6, 0,0,1,0,  0,1,0,0,1, 1,8,0,1,   0,1,0,0}, // R6 excl data
        '{6, 0,0,1,2,  0,0,0,0,1, 1,9,0,1,   0,1,0,0}, // R6 stale
        '{6, 0,0,1,9,  1,0,0,0,1, 1,6,1,1,   0,1,0,0}, // R6 instr req
        '{6, 0,0,1,8,  0,1,0,0,1, 1,5,0,1,   0,1,0,0}, // R6 shared req
        '{6, 0,0,1,3,  0,0,0,0,1, 1,10,0,1,  0,1,0,0}, // R6 ack
        '{6, 0,0,1,4,  0,0,0,0,1, 1,11,0,1,  0,1,0,0}, // R6 wb ack
        '{6, 0,0,1,5,  1,0,0,0,1, 1,12,1,1,  0,1,0,0}, // R6 inval
        '{6, 0,0,1,1,  0,0,0,0,1, 1,7,0,1,   0,1,0,0}, // R6 data
        '{7, 1,0,1,3,  0,1,0,0,1, 1,10,0,1,  0,1,0,0}, // R7 both valid
        '{8, 1,0,1,12, 0,0,0,0,1, 0,0,0,0,   0,1,0,1}, // R8 bad class beside request
        '{9, 1,0,1,1,  0,1,0,0,0, 0,0,0,0,   0,0,0,0}, // R9 stalled
        '{9, 1,2,0,0,  0,1,0,0,0, 0,0,0,0,   0,0,0,0}  // R9 stalled
    };

    function automatic logic [31:0] addr_of(input bit [1:0] s);
        case (s)
            2'd0: return A_CPU;
            2'd1: return A_NET;
            2'd2: return A_IV;
            default: return A_DV;
        endcase
    endfunction

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R10 reset state
        repeat (3) @(posedge clk);
        #1;
        chk(10, "evt_valid in reset", evt_valid, 0);
        chk(10, "errs in reset", {cpu_err, net_err}, 0);
        chk(10, "pops in reset", {cpu_pop, net_pop}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk(10, "evt_valid after reset", evt_valid, 0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cpu_valid = VECS[i].cv; cpu_kind = VECS[i].ck;
            net_valid = VECS[i].nv; net_class = VECS[i].nc;
            ic_hit = VECS[i].ih; dc_hit = VECS[i].dh;
            ic_free = VECS[i].fi; dc_free = VECS[i].fd;
            ctl_ready = VECS[i].rdy;
            #1;
            chk(VECS[i].req, $sformatf("v%0d cpu_pop", i), cpu_pop, VECS[i].cp);
            chk(VECS[i].req, $sformatf("v%0d net_pop", i), net_pop, VECS[i].np);
            chk(7, $sformatf("v%0d lookup_addr", i), lookup_addr, VECS[i].nv ? A_NET : A_CPU);
            @(posedge clk); #1;
            chk(VECS[i].req, $sformatf("v%0d evt_valid", i), evt_valid, VECS[i].ev);
            chk(VECS[i].req, $sformatf("v%0d cpu_err", i), cpu_err, VECS[i].ce);
            chk(VECS[i].req, $sformatf("v%0d net_err", i), net_err, VECS[i].ne);
            if (VECS[i].ev) begin
                chk(VECS[i].req, $sformatf("v%0d evt_kind", i), evt_kind, VECS[i].ek);
                chk(VECS[i].req, $sformatf("v%0d evt_sel", i), evt_sel, VECS[i].es);
                chk(VECS[i].req, $sformatf("v%0d evt_addr", i), evt_addr, addr_of(VECS[i].asel));
            end
        end

        // R3 sequence: evict from wrong cache, request stays, then served
        @(negedge clk);
        ctl_ready = 1'b1; net_valid = 1'b0; cpu_valid = 1'b1; cpu_kind = 3'd2;
        ic_hit = 1'b1; dc_hit = 1'b0; ic_free = 1'b1; dc_free = 1'b1;
        #1 chk(3, "seq stays at head", cpu_pop, 0);
        @(posedge clk); #1;
        chk(3, "seq evict kind", evt_kind, 3);
        chk(3, "seq evict sel", evt_sel, 1);
        @(negedge clk);
        ic_hit = 1'b0;
        #1 chk(4, "seq demand pops", cpu_pop, 1);
        @(posedge clk); #1;
        chk(4, "seq store kind", evt_kind, 2);
        chk(4, "seq store sel", evt_sel, 0);
        chk(4, "seq store addr", evt_addr, A_CPU);

        // R8 error pulse lasts one cycle
        @(negedge clk);
        cpu_kind = 3'd6;
        @(posedge clk); #1;
        chk(8, "err pulse", cpu_err, 1);
        @(negedge clk);
        cpu_valid = 1'b0;
        @(posedge clk); #1;
        chk(8, "err cleared", cpu_err, 0);
        chk(8, "idle no evt", evt_valid, 0);

        finish_run();
    end
endmodule